// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block turns a fast source clock into two matched output pairs, each with a true and a complemented signal, at one of three division ratios. A two-bit ratio code chooses divide by 4, 5 or 10. The fourth code is reserved and parks the outputs. A bypass input picks the divider's source: the oscillator clock from the synthesizer loop, or a reference clock passed straight through. An active-high master reset clears the divider at once, with no clock needed, and drives every true output low and every complemented output high.

The block is clocked logic running on a system clock `clk`. That clock is faster than either source, so each source is a sampled signal, not a clock. The divider counts source half periods, meaning every rising and every falling source edge. An output period is therefore twice the ratio in half periods, and the high phase is exactly the ratio. For the odd ratio of 5 this gives a high time of 2.5 source periods and an exact 50% duty cycle. A new ratio code or a new bypass setting is adopted only at the end of a complete output period, so no shortened pulse reaches the outputs.

Top module: `selclk_divider`

## Requirements
- R1: With ratio code 00 the output period is 4 source periods, high for 2 and low for 2. With a source that toggles every `h` system cycles, the high phase and the low phase each last `4*h` cycles.
- R2: With ratio code 01 the output period is 5 source periods. The high phase is 2.5 source periods (`5*h` cycles) and the low phase is the same.
- R3: With ratio code 10 the output period is 10 source periods, with high and low phases of `10*h` cycles each.
- R4: Ratio code 11 is reserved. Once it is adopted, every true output stays low and every complemented output stays high. This lasts until a valid code is applied, and the divider then runs at that code.
- R5: While `mr` is 1, every true output is 0 and every complemented output is 1. This takes effect without waiting for a clock edge. After `mr` returns to 0 with the ratio code at its default of 00, the block divides by 4.
- R6: With `bypass` 0 the divider counts edges of `vcoIn`. With `bypass` 1 it counts edges of `refIn`, and the half-phase length follows the reference toggle interval.
- R7: A change of the ratio code or of `bypass` is adopted only at the system edge where a complete output period ends and the next high phase begins. The period already running finishes at its old lengths. A change that is present at that boundary edge governs the period that begins there.
- R8: Each complemented output is the exact inverse of its true output in every cycle, with no added delay.
- R9: Both output pairs carry identical values in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both sources |
| mr | input | 1 | Master reset, active high, asynchronous |
| bypass | input | 1 | 0 selects the oscillator source, 1 selects the reference source |
| fsel | input | 2 | Ratio code: 00 gives /4, 01 gives /5, 10 gives /10, 11 is reserved |
| vcoIn | input | 1 | Sampled oscillator clock |
| refIn | input | 1 | Sampled reference clock |
| qTrue | output | NUM_OUT (2) | True outputs |
| qInv | output | NUM_OUT (2) | Complemented outputs |

## Verification
Two functions can land on the same system edge: adopting a new ratio code, and the period wrap that starts a high phase. The bench lets a divide-by-4 period run. It then drives the code to 10 during the last low sample before the wrap, so the new code is already present at the wrap edge. It judges the result by requiring the high phase that follows to be 10 cycles long rather than 4. A second test drives the code change early in a high phase and expects the current period to finish at 10 and 10 before a 4-cycle high phase appears.

// File: rtl/selclk_pkg.sv
package selclk_pkg;
  localparam int MAX_DIV = 10;
  localparam int CNT_W   = $clog2(2 * MAX_DIV);

  typedef enum logic [1:0] {
    SEL_D4   = 2'b00,
    SEL_D5   = 2'b01,
    SEL_D10  = 2'b10,
    SEL_RSVD = 2'b11
  } selCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             halfTick;
    logic             hold;
    logic [CNT_W-1:0] highLen;
    logic [CNT_W-1:0] lastIdx;
  } divStrobe_t;
endpackage

// File: rtl/selclk_ctrl.sv
module selclk_ctrl
  import selclk_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 5,
  parameter int DIV_C = 10
) (
  input  logic       clk,
  input  logic       mr,
  input  logic       vcoIn,
  input  logic       refIn,
  input  logic       bypass,
  input  logic [1:0] fsel,
  input  logic       wrapNow,
  output divStrobe_t strb
);
  logic     prevVco, prevRef;
  selCode_e actCode;
  logic     actByp;
  logic     loadCfg;
  logic [CNT_W-1:0] ratio;

  // configuration is adopted only while parked or at a period wrap
  assign loadCfg = (actCode == SEL_RSVD) | wrapNow;

  always_ff @(posedge clk or posedge mr) begin
    if (mr) begin
      prevVco <= 1'b0;
      prevRef <= 1'b0;
      actCode <= SEL_RSVD;
      actByp  <= 1'b0;
    end else begin
      prevVco <= vcoIn;
      prevRef <= refIn;
      if (loadCfg) begin
        actCode <= selCode_e'(fsel);
        actByp  <= bypass;
      end
    end
  end

  always_comb begin
    case (actCode)
      SEL_D5:  ratio = CNT_W'(DIV_B);
      SEL_D10: ratio = CNT_W'(DIV_C);
      default: ratio = CNT_W'(DIV_A);
    endcase
    strb.highLen  = ratio;
    strb.lastIdx  = CNT_W'((ratio << 1) - 1'b1);
    strb.hold     = (actCode == SEL_RSVD);
    strb.halfTick = actByp ? (refIn ^ prevRef) : (vcoIn ^ prevVco);
  end

  // R7: once running, config only moves at a wrap
  assert_cfg_at_boundary_R7: assert property (@(posedge clk) disable iff (mr)
    (actCode != SEL_RSVD && !wrapNow) |=> ($stable(actCode) && $stable(actByp)));
endmodule

// File: rtl/selclk_dp.sv
module selclk_dp
  import selclk_pkg::*;
(
  input  logic       clk,
  input  logic       mr,
  input  divStrobe_t strb,
  output logic       wrapNow,
  output logic       outTrue
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxtCnt;

  assign nxtCnt  = cnt + CNT_W'(1);
  assign wrapNow = strb.halfTick & ~strb.hold & (cnt >= strb.lastIdx);

  always_ff @(posedge clk or posedge mr) begin
    if (mr) begin
      cnt     <= '1;
      outTrue <= 1'b0;
    end else if (strb.hold) begin
      cnt     <= '1;
      outTrue <= 1'b0;
    end else if (strb.halfTick) begin
      if (wrapNow) begin
        cnt     <= '0;
        outTrue <= 1'b1;
      end else begin
        cnt     <= nxtCnt;
        outTrue <= (nxtCnt < strb.highLen);
      end
    end
  end

  // R4: parked divider drives low
  assert_hold_low_R4: assert property (@(posedge clk) disable iff (mr)
    strb.hold |=> !outTrue);
  // R7: no output movement without a source edge
  assert_quiet_no_tick_R7: assert property (@(posedge clk) disable iff (mr)
    (!strb.halfTick && !strb.hold) |=> $stable(outTrue));
  // R7: a high phase starts only at a full-period wrap
  assert_rise_on_wrap_R7: assert property (@(posedge clk) disable iff (mr)
    $rose(outTrue) |-> $past(wrapNow));
  // R1: running count never passes the period end
  assert_count_range_R1: assert property (@(posedge clk) disable iff (mr)
    (!strb.hold && cnt != '1) |-> (cnt <= strb.lastIdx));
endmodule

// File: rtl/selclk_divider.sv
module selclk_divider
  import selclk_pkg::*;
#(
  parameter int NUM_OUT = 2,
  parameter int DIV_A   = 4,
  parameter int DIV_B   = 5,
  parameter int DIV_C   = 10
) (
  input  logic               clk,
  input  logic               mr,
  input  logic               bypass,
  input  logic [1:0]         fsel,
  input  logic               vcoIn,
  input  logic               refIn,
  output logic [NUM_OUT-1:0] qTrue,
  output logic [NUM_OUT-1:0] qInv
);
  divStrobe_t strb;
  logic       wrapNow;
  logic       outTrue;

  selclk_ctrl #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) uCtrl (
    .clk(clk), .mr(mr), .vcoIn(vcoIn), .refIn(refIn), .bypass(bypass),
    .fsel(fsel), .wrapNow(wrapNow), .strb(strb)
  );

  selclk_dp uDp (
    .clk(clk), .mr(mr), .strb(strb), .wrapNow(wrapNow), .outTrue(outTrue)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : gPair
    assign qTrue[g] = outTrue;
    assign qInv[g]  = ~outTrue;
  end
endmodule

// File: tb/sim_selclk_divider.sv
`timescale 1ns/1ps
module sim_selclk_divider;
  logic       clk = 1'b0;
  logic       mr = 1'b1;
  logic       bypass = 1'b0;
  logic [1:0] fsel = 2'b00;
  logic       vcoIn = 1'b0;
  logic       refIn = 1'b0;
  logic [1:0] qTrue, qInv;

  int checks = 0, errors = 0;
  int vHalf = 1, rHalf = 3, vCnt = 0, rCnt = 0;
  int compMiss = 0, pairMiss = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  selclk_divider u0 (.clk(clk), .mr(mr), .bypass(bypass), .fsel(fsel),
                     .vcoIn(vcoIn), .refIn(refIn), .qTrue(qTrue), .qInv(qInv));

  // source generators, driven away from the active edge
  always @(negedge clk) begin
    vCnt++;
    if (vCnt >= vHalf) begin vCnt = 0; vcoIn <= ~vcoIn; end
    rCnt++;
    if (rCnt >= rHalf) begin rCnt = 0; refIn <= ~refIn; end
  end

  // R8 / R9 monitor on every sample
  always @(negedge clk) begin
    if (qInv !== ~qTrue) compMiss++;
    if (qTrue[1] !== qTrue[0]) pairMiss++;
  end

  // row: fsel[18:17] bypass[16] vHalf[15:12] rHalf[11:8] expected run[7:0]
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {2'b00, 1'b0, 4'd1, 4'd3, 8'd4},
    {2'b01, 1'b0, 4'd1, 4'd3, 8'd5},
    {2'b10, 1'b0, 4'd1, 4'd3, 8'd10},
    {2'b00, 1'b1, 4'd1, 4'd3, 8'd12},
    {2'b01, 1'b1, 4'd1, 4'd2, 8'd10},
    {2'b10, 1'b0, 4'd2, 4'd3, 8'd20}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // consecutive samples equal to val, starting at the current sample
  task automatic countLevel(input logic val, output int n);
    n = 0;
    while (qTrue[0] === val && n < 3000) begin n++; @(negedge clk); end
  endtask

  task automatic waitRise();
    int g = 0;
    while (qTrue[0] !== 1'b0 && g < 3000) begin g++; @(negedge clk); end
    while (qTrue[0] !== 1'b1 && g < 3000) begin g++; @(negedge clk); end
  endtask

  task automatic getRuns(output int hi, output int lo);
    waitRise();
    countLevel(1'b1, hi);
    countLevel(1'b0, lo);
  endtask

  initial begin
    int hi, lo, hi2;
    string tag;
    // R5: reset state
    repeat (4) @(negedge clk);
    check(qTrue == 2'b00, "R5 reset true low", qTrue, 0);
    check(qInv == 2'b11, "R5 reset inv high", qInv, 3);
    mr <= 1'b0;
    getRuns(hi, lo);
    getRuns(hi, lo);
    check(hi == 4 && lo == 4, "R5 default /4 after reset", hi * 100 + lo, 404);

    // table walk: R1 R2 R3 R6
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fsel = VEC[i][18:17]; bypass = VEC[i][16];
      vHalf = int'(VEC[i][15:12]); rHalf = int'(VEC[i][11:8]);
      getRuns(hi, lo); getRuns(hi, lo); getRuns(hi, lo);
      if (VEC[i][16]) tag = "R6";
      else if (VEC[i][18:17] == 2'b00) tag = "R1";
      else if (VEC[i][18:17] == 2'b01) tag = "R2";
      else tag = "R3";
      check(hi == int'(VEC[i][7:0]), {tag, " high run"}, hi, int'(VEC[i][7:0]));
      check(lo == int'(VEC[i][7:0]), {tag, " low run"}, lo, int'(VEC[i][7:0]));
    end

    // R7: change early in a high phase, /10 -> /4
    @(negedge clk);
    vHalf = 1; bypass = 0; fsel = 2'b10;
    getRuns(hi, lo); getRuns(hi, lo);
    waitRise();
    fsel = 2'b00;
    countLevel(1'b1, hi);
    countLevel(1'b0, lo);
    countLevel(1'b1, hi2);
    check(hi == 10 && lo == 10, "R7 running period finishes at old ratio", hi * 100 + lo, 1010);
    check(hi2 == 4, "R7 new ratio from next period", hi2, 4);

    // R7: change present exactly at the wrap edge, /4 -> /10
    getRuns(hi, lo); getRuns(hi, lo);
    waitRise();
    repeat (7) @(negedge clk);
    check(qTrue[0] == 1'b0, "R7 last low sample before wrap", qTrue[0], 0);
    fsel = 2'b10;
    @(negedge clk);
    countLevel(1'b1, hi);
    check(hi == 10, "R7 boundary change governs new period", hi, 10);

    // R4: reserved code parks the outputs
    fsel = 2'b11;
    repeat (50) @(negedge clk);
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      if (qTrue !== 2'b00 || qInv !== 2'b11) hi++;
      @(negedge clk);
    end
    check(hi == 0, "R4 reserved holds true low inv high", hi, 0);
    fsel = 2'b01;
    getRuns(hi, lo); getRuns(hi, lo);
    check(hi == 5 && lo == 5, "R4 recovery at valid code", hi * 100 + lo, 505);

    // R5: asynchronous reset during a high phase
    waitRise();
    #1 mr = 1'b1;
    #0.5;
    check(qTrue == 2'b00 && qInv == 2'b11, "R5 async clear mid-high", qTrue, 0);
    repeat (5) @(negedge clk);
    check(qTrue == 2'b00, "R5 held during reset", qTrue, 0);
    fsel = 2'b00;
    mr = 1'b0;
    getRuns(hi, lo); getRuns(hi, lo);
    check(hi == 4 && lo == 4, "R5 /4 after second release", hi * 100 + lo, 404);

    check(compMiss == 0, "R8 inverse exact every cycle", compMiss, 0);
    check(pairMiss == 0, "R9 pairs identical every cycle", pairMiss, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..all actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule